// File: doc/BRIEF.md
# Pipeline Arithmetic-Overflow Exception Controller

This block supervises a five-stage 16-bit pipeline (fetch, decode, execute, memory, write-back) and handles unsigned arithmetic overflow precisely. It keeps the valid bit of each of the four inter-stage latches. It watches the add operands and the program counter of the instruction in the execute stage. When a valid add carries out of bit 15, the block raises a trap in that same cycle. On the next rising edge it does several things at once:

- It turns the decode and execute latches into bubbles.
- It cancels the faulting instruction so that its result never reaches write-back.
- It lets the older instruction drain through memory and write-back.
- It records the faulting address and the resume address (fault + 1).
- It redirects fetch to a fixed handler address.

The faulting address is then written into reserved register 15 through the register-file write port. This happens in the first cycle in which the write-back stage is not using that port. A jump-return decoded in the decode stage redirects fetch to the saved resume address. The recorded fault address stays visible on an output, and a move-from-coprocessor read can use it.

The ALU, register file, memories and the PC register lie outside the block and appear only as ports. Nested exceptions are not handled.

Top module: `ovx_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, all four latch valid outputs, epc and epc_ret clear to 0. After that edge, with no pending work, rf_we and pc_load are 0.
- R2: Without a trap, on each rising edge ifid_vld takes fetch_valid, idex_vld takes ifid_vld and exmem_vld takes idex_vld.
- R3: trap is high in a cycle exactly when idex_vld=1, ex_is_add=1 and ex_opa+ex_opb exceeds 65535 (for example 32+65527). While trap is high, pc_load=1 and pc_target equals HANDLER_ADDR.
- R4: On the rising edge after a trap cycle, ifid_vld, idex_vld and exmem_vld all become 0, whatever fetch_valid was.
- R5: memwb_vld always takes the previous exmem_vld, including on a trap edge. While memwb_vld=1 and wb_we=1, rf_we=1, rf_waddr=wb_rd and rf_wdata=wb_data.
- R6: On the edge after a trap cycle, epc takes ex_pc and epc_ret takes ex_pc+1 modulo 2^16. Otherwise both hold their value.
- R7: After a trap, the saved epc is written to register 15 (rf_we=1, rf_waddr=15, rf_wdata=epc) exactly once. The write happens in the first cycle, starting with the cycle after the trap, in which memwb_vld&wb_we is 0.
- R8: A carry from an add while idex_vld=0, or from an instruction with ex_is_add=0, causes no trap and leaves epc unchanged.
- R9: When jr_ret=1, ifid_vld=1 and there is no trap, pc_load=1 and pc_target=epc_ret. A trap takes priority over jr_ret. With neither, pc_load=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A real instruction is being fetched into the decode latch |
| ex_is_add | input | 1 | Instruction in execute is an unsigned add |
| ex_opa | input | 16 | First add operand in execute |
| ex_opb | input | 16 | Second add operand in execute |
| ex_pc | input | 16 | Address of the instruction in execute |
| wb_we | input | 1 | Instruction in write-back writes a register |
| wb_rd | input | 4 | Destination register of the write-back instruction |
| wb_data | input | 16 | Result of the write-back instruction |
| jr_ret | input | 1 | Decode holds a jump through the reserved register |
| trap | output | 1 | Overflow trap detected this cycle |
| ifid_vld | output | 1 | Decode latch holds a live instruction |
| idex_vld | output | 1 | Execute latch holds a live instruction |
| exmem_vld | output | 1 | Memory latch holds a live instruction |
| memwb_vld | output | 1 | Write-back latch holds a live instruction |
| pc_load | output | 1 | Load pc_target into the PC at the next edge |
| pc_target | output | 16 | Redirect address |
| epc | output | 16 | Recorded faulting address |
| epc_ret | output | 16 | Recorded resume address |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write address |
| rf_wdata | output | 16 | Register-file write data |

## Verification
The assertions assume that reset is held for at least two rising edges, so that every $past value comes from reset state. They also assume that wb_rd, wb_data and the execute operands are always driven to known values. The stimulus meets both conditions: it drives every input on the falling edge, and it sweeps operand pairs around the 2^16 carry boundary. That sweep is mixed with the fetch-valid, add-select, write-enable and jump-return patterns, so that traps land both with and without a draining write and with and without a queued register-15 write.

// File: rtl/ovx_pkg.sv
// Shared types for the overflow exception controller.
// Assumes: one valid bit per inter-stage latch; no other per-latch state is kept here.
package ovx_pkg;

    // valid bits of the four pipeline latches, youngest first
    typedef struct packed {
        logic ifid;
        logic idex;
        logic exmem;
        logic memwb;
    } stage_vld_t;

    // selector for the source of the register-file write port
    typedef enum logic [1:0] {
        WSRC_NONE = 2'd0,
        WSRC_WB   = 2'd1,
        WSRC_RESV = 2'd2
    } wsrc_t;

endpackage

// File: rtl/ovx_ovf_detect.sv
// Unsigned add overflow detector for the execute stage.
// Flags a carry out of the top bit, qualified by a live add in execute.
// Assumes: operands are the raw ALU inputs; non-add instructions never flag.
module ovx_ovf_detect #(
    parameter int DW = 16
) (
    input  logic          ex_live,
    input  logic          is_add,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic          ovf
);
    localparam int SW = DW + 1;

    logic [SW-1:0] wide_sum;

    // widened sum; its top bit is the carry out
    always_comb begin
        wide_sum = {1'b0, opa} + {1'b0, opb};
        ovf      = ex_live & is_add & wide_sum[SW-1];
    end
endmodule

// File: rtl/ovx_valid_pipe.sv
// Valid-bit shadow of the four pipeline latches.
// On flush the decode, execute and memory latches become bubbles; write-back still drains.
// Assumes: the pipeline never stalls; every latch advances every cycle.
module ovx_valid_pipe
    import ovx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch_valid,
    input  logic       flush,
    output stage_vld_t vld
);
    // advance the valid bits, inserting bubbles on flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            vld.ifid  <= fetch_valid & ~flush;
            vld.idex  <= vld.ifid    & ~flush;
            vld.exmem <= vld.idex    & ~flush;
            vld.memwb <= vld.exmem;
        end
    end
endmodule

// File: rtl/ovx_epc_regs.sv
// Fault and resume address registers, plus the pending write of the reserved register.
// Assumes: no second trap arrives while handling (a new trap simply overwrites the record).
module ovx_epc_regs #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trap,
    input  logic [AW-1:0] ex_pc,
    input  logic          wb_busy,
    output logic [AW-1:0] epc,
    output logic [AW-1:0] epc_ret,
    output logic          resv_pend
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // capture the faulting and resume addresses on a trap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc     <= '0;
            epc_ret <= '0;
        end else if (trap) begin
            epc     <= ex_pc;
            epc_ret <= ex_pc + ONE;
        end
    end

    // queue one reserved-register write; retire it once the port is free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_pend <= 1'b0;
        end else if (trap) begin
            resv_pend <= 1'b1;
        end else if (resv_pend && !wb_busy) begin
            resv_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/ovx_ctrl.sv
// Top of the arithmetic-overflow exception controller.
// Detects overflow in execute, flushes the younger latches, drains the older one,
// records fault/resume addresses, redirects fetch, and writes the fault address to
// the reserved register through the shared register-file write port.
// Assumes: the PC register and register file are external; write-back has port priority.
module ovx_ctrl
    import ovx_pkg::*;
#(
    parameter int              DW           = 16,
    parameter int              AW           = 16,
    parameter int              RA           = 4,
    parameter int              RESV_REG     = 15,
    parameter logic [AW-1:0]   HANDLER_ADDR = 16'h0040
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic          ex_is_add,
    input  logic [DW-1:0] ex_opa,
    input  logic [DW-1:0] ex_opb,
    input  logic [AW-1:0] ex_pc,
    input  logic          wb_we,
    input  logic [RA-1:0] wb_rd,
    input  logic [DW-1:0] wb_data,
    input  logic          jr_ret,
    output logic          trap,
    output logic          ifid_vld,
    output logic          idex_vld,
    output logic          exmem_vld,
    output logic          memwb_vld,
    output logic          pc_load,
    output logic [AW-1:0] pc_target,
    output logic [AW-1:0] epc,
    output logic [AW-1:0] epc_ret,
    output logic          rf_we,
    output logic [RA-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata
);
    localparam logic [RA-1:0] RESV_ADDR = RA'(RESV_REG);

    stage_vld_t vld;
    logic       ovf;
    logic       wb_busy;
    logic       resv_pend;
    wsrc_t      wsrc;

    ovx_ovf_detect #(.DW(DW)) u_det (
        .ex_live (vld.idex),
        .is_add  (ex_is_add),
        .opa     (ex_opa),
        .opb     (ex_opb),
        .ovf     (ovf)
    );

    ovx_valid_pipe u_vld (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .flush       (ovf),
        .vld         (vld)
    );

    ovx_epc_regs #(.AW(AW)) u_epc (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap      (ovf),
        .ex_pc     (ex_pc),
        .wb_busy   (wb_busy),
        .epc       (epc),
        .epc_ret   (epc_ret),
        .resv_pend (resv_pend)
    );

    // expose the latch valid bits
    always_comb begin
        trap      = ovf;
        ifid_vld  = vld.ifid;
        idex_vld  = vld.idex;
        exmem_vld = vld.exmem;
        memwb_vld = vld.memwb;
    end

    // fetch redirect: trap to handler first, else return from decode
    always_comb begin
        pc_load   = 1'b0;
        pc_target = epc_ret;
        if (ovf) begin
            pc_load   = 1'b1;
            pc_target = HANDLER_ADDR;
        end else if (jr_ret && vld.ifid) begin
            pc_load   = 1'b1;
        end
    end

    // arbitrate the register-file write port
    always_comb begin
        wb_busy = vld.memwb & wb_we;
        if (wb_busy)        wsrc = WSRC_WB;
        else if (resv_pend) wsrc = WSRC_RESV;
        else                wsrc = WSRC_NONE;
    end

    // drive the register-file write port from the selected source
    always_comb begin
        unique case (wsrc)
            WSRC_WB: begin
                rf_we    = 1'b1;
                rf_waddr = wb_rd;
                rf_wdata = wb_data;
            end
            WSRC_RESV: begin
                rf_we    = 1'b1;
                rf_waddr = RESV_ADDR;
                rf_wdata = DW'(epc);
            end
            default: begin
                rf_we    = 1'b0;
                rf_waddr = '0;
                rf_wdata = '0;
            end
        endcase
    end
endmodule

// File: rtl/ovx_ctrl_chk.sv
// Assertion checker for ovx_ctrl, attached by bind below.
// Assumes: reset is held for at least two rising edges.
module ovx_ctrl_chk #(
    parameter int            DW           = 16,
    parameter int            AW           = 16,
    parameter int            RA           = 4,
    parameter int            RESV_REG     = 15,
    parameter logic [AW-1:0] HANDLER_ADDR = 16'h0040
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ex_is_add,
    input logic [AW-1:0] ex_pc,
    input logic          wb_we,
    input logic          jr_ret,
    input logic          trap,
    input logic          ifid_vld,
    input logic          idex_vld,
    input logic          exmem_vld,
    input logic          memwb_vld,
    input logic          pc_load,
    input logic [AW-1:0] pc_target,
    input logic [AW-1:0] epc,
    input logic [AW-1:0] epc_ret,
    input logic          rf_we,
    input logic [RA-1:0] rf_waddr,
    input logic [DW-1:0] rf_wdata
);
    // R3: a trap redirects to the handler
    p_handler_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (pc_load && pc_target == HANDLER_ADDR));

    // R4: younger latches become bubbles after a trap
    p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (!ifid_vld && !idex_vld && !exmem_vld));

    // R5: write-back latch always drains from the memory latch
    p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (memwb_vld == $past(exmem_vld)));

    // R6: fault and resume addresses are captured on a trap
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (epc == $past(ex_pc) && epc_ret == $past(ex_pc) + AW'(1)));

    // R6: addresses hold without a trap
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |=> $stable(epc));

    // R7: a reserved-register write not from write-back carries the fault address
    p_resv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !(memwb_vld && wb_we)) |-> (rf_waddr == RA'(RESV_REG) && rf_wdata == DW'(epc)));

    // R8: no trap without a live add in execute
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idex_vld || !ex_is_add) |-> !trap);

    // R9: jump-return from decode targets the resume address
    p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (jr_ret && ifid_vld && !trap) |-> (pc_load && pc_target == epc_ret));
endmodule

bind ovx_ctrl ovx_ctrl_chk #(
    .DW(DW), .AW(AW), .RA(RA), .RESV_REG(RESV_REG), .HANDLER_ADDR(HANDLER_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ex_is_add(ex_is_add), .ex_pc(ex_pc),
    .wb_we(wb_we), .jr_ret(jr_ret), .trap(trap), .ifid_vld(ifid_vld),
    .idex_vld(idex_vld), .exmem_vld(exmem_vld), .memwb_vld(memwb_vld),
    .pc_load(pc_load), .pc_target(pc_target), .epc(epc), .epc_ret(epc_ret),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
);

// File: tb/ovx_ctrl_tb_top.sv
// Self-checking bench: sweeps operand pairs around the carry boundary, mixed with
// fetch, write-back and return patterns, against a bench model of the latches.
module ovx_ctrl_tb_top;
    localparam int            CLK_PERIOD = 10;
    localparam logic [15:0]   HANDLER    = 16'h0040;
    localparam int            NCYC       = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0, ex_is_add = 1'b0, wb_we = 1'b0, jr_ret = 1'b0;
    logic [15:0] ex_opa = '0, ex_opb = '0, ex_pc = '0, wb_data = '0;
    logic [3:0]  wb_rd = '0;
    logic        trap, ifid_vld, idex_vld, exmem_vld, memwb_vld, pc_load, rf_we;
    logic [15:0] pc_target, epc, epc_ret, rf_wdata;
    logic [3:0]  rf_waddr;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model state
    bit          m_ifid, m_idex, m_exmem, m_memwb, m_pend, m_prev_trap;
    logic [15:0] m_epc, m_ret;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovx_ctrl #(.HANDLER_ADDR(HANDLER)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .ex_is_add(ex_is_add),
        .ex_opa(ex_opa), .ex_opb(ex_opb), .ex_pc(ex_pc), .wb_we(wb_we), .wb_rd(wb_rd),
        .wb_data(wb_data), .jr_ret(jr_ret), .trap(trap), .ifid_vld(ifid_vld),
        .idex_vld(idex_vld), .exmem_vld(exmem_vld), .memwb_vld(memwb_vld),
        .pc_load(pc_load), .pc_target(pc_target), .epc(epc), .epc_ret(epc_ret),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // compare all outputs with the model, then advance the model one edge
    task automatic step();
        bit          e_trap, e_load, e_we;
        logic [16:0] sum;
        logic [15:0] e_tgt, e_wdata;
        logic [3:0]  e_waddr;
        string       vt;
        #1;
        sum    = {1'b0, ex_opa} + {1'b0, ex_opb};
        e_trap = m_idex && ex_is_add && sum[16];
        vt     = m_prev_trap ? "R4" : "R2";
        check(vt,   "ifid_vld",  ifid_vld,  m_ifid);
        check(vt,   "idex_vld",  idex_vld,  m_idex);
        check(vt,   "exmem_vld", exmem_vld, m_exmem);
        check("R5", "memwb_vld", memwb_vld, m_memwb);
        check("R6", "epc",       epc,       m_epc);
        check("R6", "epc_ret",   epc_ret,   m_ret);
        check((sum[16] && !e_trap) ? "R8" : "R3", "trap", trap, e_trap);
        e_load = e_trap || (jr_ret && m_ifid);
        e_tgt  = e_trap ? HANDLER : m_ret;
        check(e_trap ? "R3" : "R9", "pc_load", pc_load, e_load);
        if (e_load) check(e_trap ? "R3" : "R9", "pc_target", pc_target, e_tgt);
        e_we = 1'b0; e_waddr = '0; e_wdata = '0;
        if (m_memwb && wb_we) begin
            e_we = 1'b1; e_waddr = wb_rd; e_wdata = wb_data;
        end else if (m_pend) begin
            e_we = 1'b1; e_waddr = 4'd15; e_wdata = m_epc;
        end
        vt = (m_memwb && wb_we) ? "R5" : "R7";
        check(vt, "rf_we", rf_we, e_we);
        if (e_we) begin
            check(vt, "rf_waddr", rf_waddr, e_waddr);
            check(vt, "rf_wdata", rf_wdata, e_wdata);
        end
        // model next state
        if (e_trap) m_pend = 1'b1;
        else if (m_pend && !(m_memwb && wb_we)) m_pend = 1'b0;
        if (e_trap) begin
            m_epc = ex_pc;
            m_ret = ex_pc + 16'd1;
        end
        m_memwb     = m_exmem;
        m_exmem     = m_idex && !e_trap;
        m_idex      = m_ifid && !e_trap;
        m_ifid      = fetch_valid && !e_trap;
        m_prev_trap = e_trap;
        @(negedge clk);
    endtask

    task automatic drive(input bit fv, input bit add, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] pc, input bit we, input logic [3:0] rd,
                         input logic [15:0] d, input bit jr);
        fetch_valid = fv; ex_is_add = add; ex_opa = a; ex_opb = b; ex_pc = pc;
        wb_we = we; wb_rd = rd; wb_data = d; jr_ret = jr;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        // R1: reset state after synchronous reset edges
        drive(1, 1, 16'hFFFF, 16'hFFFF, 16'h1234, 1, 4'd3, 16'h5555, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "ifid_vld",  ifid_vld,  0);
        check("R1", "idex_vld",  idex_vld,  0);
        check("R1", "exmem_vld", exmem_vld, 0);
        check("R1", "memwb_vld", memwb_vld, 0);
        check("R1", "epc",       epc,       0);
        check("R1", "epc_ret",   epc_ret,   0);
        check("R1", "rf_we",     rf_we,     0);
        check("R1", "pc_load",   pc_load,   0);
        m_ifid = 0; m_idex = 0; m_exmem = 0; m_memwb = 0; m_pend = 0;
        m_prev_trap = 0; m_epc = '0; m_ret = '0;
        rst_n = 1'b1;
        // R3 directed: fill pipe, then 32 + 65527 in execute at address 103
        drive(1, 0, 16'd0, 16'd0, 16'd100, 1, 4'd2, 16'h0A0A, 0); step();
        drive(1, 0, 16'd0, 16'd0, 16'd101, 1, 4'd2, 16'h0B0B, 0); step();
        drive(1, 0, 16'd5, 16'd6, 16'd102, 1, 4'd4, 16'h0C0C, 0); step();
        drive(1, 1, 16'd32, 16'd65527, 16'd103, 1, 4'd5, 16'h0D0D, 0); step();
        drive(1, 0, 16'd0, 16'd0, 16'd0, 1, 4'd6, 16'h0E0E, 0); step();
        drive(1, 0, 16'd0, 16'd0, 16'd0, 1, 4'd6, 16'h0F0F, 0); step();
        // R9 directed: return from decode
        drive(1, 0, 16'd0, 16'd0, 16'd0, 0, 4'd0, 16'h0, 1); step();
        drive(1, 0, 16'd0, 16'd0, 16'd0, 0, 4'd0, 16'h0, 1); step();
        // sweep: operands around the carry boundary, mixed control patterns
        for (int i = 0; i < NCYC; i++) begin
            logic [15:0] a, b;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a  = 16'(i * 16'h3A7) ^ {lf[7:0], 8'h00};
            b  = 16'hFFFF - a + 16'(i % 5) - 16'd2;
            drive(lf[0] | lf[1], lf[2], a, b, 16'(i * 7 + 16'hFFF0),
                  lf[3] & lf[4], lf[11:8], lf ^ 16'h5A5A, lf[5] & lf[6] & lf[9]);
            step();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule